// File: doc/BRIEF.md
# Bus Event Capture Unit

This block sits beside an 8-bit microprocessor and watches its bus from a fast monitor clock. It sees the active-low strobes for memory request, I/O request, read, write and opcode fetch, together with the 16-bit address bus and the 8-bit data bus. Each of its two capture slots is set to one kind of bus event. When that event finishes, the slot keeps the address and data that were present while the event was active. A slot can also be set to follow the live buses or to stay idle.

Every bus input, and the view button, is brought into the monitor clock domain through two flip-flops. An event counts as active while both of its component strobes are low. The slot captures on the first monitor cycle in which the event is no longer active, and it stores the values it held on the last cycle the event was active. One display output shows a single slot at a time. A debounced view button flips the display from one slot to the other on each press.

Top module: `bus_capture_unit`

## Requirements
- R1: While reset is asserted, both slots are marked empty, the display shows slot 0, and the displayed address and data are zero.
- R2: A slot with select code 1 captures at the end of each memory read, meaning memory request and read both low.
- R3: A slot with select code 2 captures at the end of each memory write, meaning memory request and write both low.
- R4: A slot with select code 3 captures at the end of an I/O read (I/O request with read). A slot with select code 4 captures at the end of an I/O write (I/O request with write).
- R5: A slot with select code 5 captures at the end of an opcode fetch, meaning opcode-fetch and memory request both low.
- R6: The captured address and data are those present while the event was still active. A bus change that arrives together with the strobe release is not stored.
- R7: While an event is still active, the slot contents do not change.
- R8: A slot with select code 0 follows the live address and data buses. A bus change reaches the display on the third rising clock edge after it is applied, and the slot is marked valid.
- R9: A slot with select code 6 or 7 never captures. Its contents and its valid flag stay as they were.
- R10: A slot ignores every bus event other than the one its code selects.
- R11: The two slots are independent, and both capture when one event matches both of their codes.
- R12: The view button must be stable for DEBOUNCE_CYCLES monitor clocks before it counts. Each accepted rising level flips the displayed slot. A shorter pulse, a held button and a release leave the displayed slot unchanged.
- R13: A slot's valid flag goes high on its first capture and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode-fetch strobe, active low |
| bus_addr | input | 16 | CPU address bus |
| bus_data | input | 8 | CPU data bus |
| trig_sel0 | input | 3 | Select code for slot 0 (0 follow, 1 to 5 events, 6 and 7 off) |
| trig_sel1 | input | 3 | Select code for slot 1 |
| view_btn | input | 1 | Raw view button, high when pressed |
| disp_addr | output | 16 | Address held by the displayed slot |
| disp_data | output | 8 | Data held by the displayed slot |
| disp_valid | output | 1 | Valid flag of the displayed slot |
| disp_sel | output | 1 | Index of the displayed slot |

## Verification
The bench flips address and data at the same moment the strobes are released. A design that captured after the event had ended would store the flipped values instead of the ones present during the event. It holds an event active for many cycles and reads the display in the middle of it, which exposes a slot that updates too early. It times the follow mode to the exact edge, so an extra or a missing synchronizer stage shows up as a wrong value. It also runs an opcode fetch that also asserts read, runs unmatched events, and puts slots in the off codes. This catches a slot that fires on the wrong strobe pair or writes while disabled. Button pulses shorter than the debounce window, a long hold and a release check that the view flips only once per accepted press.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SLOTS  = 2;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        TRIG_FOLLOW = 3'd0,
        TRIG_MEM_RD = 3'd1,
        TRIG_MEM_WR = 3'd2,
        TRIG_IO_RD  = 3'd3,
        TRIG_IO_WR  = 3'd4,
        TRIG_FETCH  = 3'd5,
        TRIG_OFF_A  = 3'd6,
        TRIG_OFF_B  = 3'd7
    } trig_e;

    // strobes after inversion: 1 means asserted
    typedef struct packed {
        logic mreq;
        logic iorq;
        logic rd;
        logic wr;
        logic m1;
    } strobe_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } snap_t;

    typedef struct packed {
        strobe_t stb;
        snap_t   bus;
    } busview_t;

    localparam int BUSVIEW_W = $bits(busview_t);

    function automatic logic event_active(trig_e code, strobe_t s);
        logic hit;
        case (code)
            TRIG_MEM_RD: hit = s.mreq & s.rd;
            TRIG_MEM_WR: hit = s.mreq & s.wr;
            TRIG_IO_RD:  hit = s.iorq & s.rd;
            TRIG_IO_WR:  hit = s.iorq & s.wr;
            TRIG_FETCH:  hit = s.m1 & s.mreq;
            default:     hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/bcu_sync.sv
module bcu_sync #(
    parameter int          WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = d_in;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stage1 <= RST_VAL;
            st_q.stage2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign d_out = st_q.stage2;

endmodule

// File: rtl/bcu_debounce.sv
module bcu_debounce #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic level,
    output logic press
);

    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             stable;
        logic [CNT_W-1:0] cnt;
    } deb_st_t;

    deb_st_t st_d, st_q;
    logic    press_c;

    always_comb begin
        st_d    = st_q;
        press_c = 1'b0;
        st_d.s1 = raw_in;
        st_d.s2 = st_q.s1;
        if (st_q.s2 == st_q.stable) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.stable = st_q.s2;
            st_d.cnt    = '0;
            press_c     = st_q.s2;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.stable;
    assign press = press_c;

endmodule

// File: rtl/bcu_slot.sv
module bcu_slot
    import bcu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  trig_e   code,
    input  strobe_t stb,
    input  snap_t   bus,
    output snap_t   cap,
    output logic    valid
);

    typedef struct packed {
        logic  was_active;
        snap_t held;
        snap_t cap;
        logic  valid;
    } slot_st_t;

    slot_st_t st_d, st_q;
    logic     active;

    always_comb begin
        st_d            = st_q;
        active          = event_active(code, stb);
        st_d.was_active = active;
        if (active) begin
            st_d.held = bus;
        end
        if (code == TRIG_FOLLOW) begin
            st_d.cap   = bus;
            st_d.valid = 1'b1;
        end else if (st_q.was_active && !active) begin
            // trailing edge: store what was seen during the event
            st_d.cap   = st_q.held;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap   = st_q.cap;
    assign valid = st_q.valid;

endmodule

// File: rtl/bus_capture_unit.sv
module bus_capture_unit
    import bcu_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              m1_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [CODE_W-1:0] trig_sel0,
    input  logic [CODE_W-1:0] trig_sel1,
    input  logic              view_btn,
    output logic [ADDR_W-1:0] disp_addr,
    output logic [DATA_W-1:0] disp_data,
    output logic              disp_valid,
    output logic              disp_sel
);

    busview_t              raw_view;
    busview_t              sync_view;
    logic [BUSVIEW_W-1:0]  sync_bits;
    logic [CODE_W-1:0]     slot_code [SLOTS];
    snap_t [SLOTS-1:0]     slot_cap;
    logic  [SLOTS-1:0]     slot_valid;
    logic                  btn_level;
    logic                  press_pulse;

    typedef struct packed {
        logic view;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        raw_view.stb.mreq = ~mreq_n;
        raw_view.stb.iorq = ~iorq_n;
        raw_view.stb.rd   = ~rd_n;
        raw_view.stb.wr   = ~wr_n;
        raw_view.stb.m1   = ~m1_n;
        raw_view.bus.addr = bus_addr;
        raw_view.bus.data = bus_data;
    end

    bcu_sync #(
        .WIDTH   (BUSVIEW_W),
        .RST_VAL ('0)
    ) i_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_view),
        .d_out (sync_bits)
    );

    assign sync_view    = busview_t'(sync_bits);
    assign slot_code[0] = trig_sel0;
    assign slot_code[1] = trig_sel1;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        bcu_slot i_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .code  (trig_e'(slot_code[g])),
            .stb   (sync_view.stb),
            .bus   (sync_view.bus),
            .cap   (slot_cap[g]),
            .valid (slot_valid[g])
        );
    end

    bcu_debounce #(
        .CYCLES (DEBOUNCE_CYCLES)
    ) i_view_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (view_btn),
        .level  (btn_level),
        .press  (press_pulse)
    );

    always_comb begin
        st_d      = st_q;
        st_d.view = st_q.view ^ press_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign disp_sel   = st_q.view;
    assign disp_addr  = slot_cap[st_q.view].addr;
    assign disp_data  = slot_cap[st_q.view].data;
    assign disp_valid = slot_valid[st_q.view];

endmodule

// File: rtl/bcu_checker.sv
module bcu_checker
    import bcu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] sel0,
    input logic [CODE_W-1:0] sel1,
    input logic [SLOTS-1:0]  valid,
    input snap_t [SLOTS-1:0] caps,
    input logic              disp_sel,
    input logic              press
);

    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |-> (valid == '0 && !disp_sel));

    assert_valid_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(valid) & valid) == $past(valid)));

    assert_follow_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0 == 3'd0 && $past(sel0) == 3'd0) |=> valid[0]);

    assert_off_hold0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0[2:1] == 2'b11 && $past(sel0[2:1]) == 2'b11)
            |-> ($stable(valid[0]) && $stable(caps[0])));

    assert_off_hold1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel1[2:1] == 2'b11 && $past(sel1[2:1]) == 2'b11)
            |-> ($stable(valid[1]) && $stable(caps[1])));

    assert_view_needs_press_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_sel != $past(disp_sel)) |-> $past(press));

endmodule

bind bus_capture_unit bcu_checker i_bcu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel0     (trig_sel0),
    .sel1     (trig_sel1),
    .valid    (slot_valid),
    .caps     (slot_cap),
    .disp_sel (disp_sel),
    .press    (press_pulse)
);

// File: tb/test_bus_capture_unit.sv
module test_bus_capture_unit;

    localparam int DEB = 4;
    localparam int NV  = 9;

    typedef struct packed {
        logic [2:0]  s0;
        logic [2:0]  s1;
        logic [2:0]  kind;   // 1 mem rd, 2 mem wr, 3 io rd, 4 io wr, 5 fetch
        logic [15:0] a;
        logic [7:0]  d;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{3'd1, 3'd2, 3'd1, 16'h1234, 8'h5A},
        '{3'd1, 3'd2, 3'd2, 16'h2345, 8'hA5},
        '{3'd3, 3'd4, 3'd3, 16'h0040, 8'h11},
        '{3'd3, 3'd4, 3'd4, 16'h0041, 8'h22},
        '{3'd5, 3'd1, 3'd5, 16'h0100, 8'hED},
        '{3'd5, 3'd1, 3'd3, 16'h0010, 8'h33},
        '{3'd6, 3'd7, 3'd1, 16'h4444, 8'h44},
        '{3'd2, 3'd2, 3'd2, 16'hFFFF, 8'h00},
        '{3'd4, 3'd3, 3'd1, 16'h0000, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic [2:0]  trig_sel0 = 3'd6, trig_sel1 = 3'd6;
    logic        view_btn = 1'b0;
    logic [15:0] disp_addr;
    logic [7:0]  disp_data;
    logic        disp_valid;
    logic        disp_sel;

    int checks = 0;
    int fails  = 0;
    logic        exp_v [2];
    logic [15:0] exp_a [2];
    logic [7:0]  exp_d [2];

    always #10 clk = ~clk;

    bus_capture_unit #(.DEBOUNCE_CYCLES(DEB)) i_bus_capture_unit (
        .clk(clk), .rst_n(rst_n),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .trig_sel0(trig_sel0), .trig_sel1(trig_sel1),
        .view_btn(view_btn),
        .disp_addr(disp_addr), .disp_data(disp_data),
        .disp_valid(disp_valid), .disp_sel(disp_sel)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_event(logic [2:0] kind, logic [15:0] a, logic [7:0] d, int hold);
        @(negedge clk);
        bus_addr = a;
        bus_data = d;
        case (kind)
            3'd1: begin mreq_n = 1'b0; rd_n = 1'b0; end
            3'd2: begin mreq_n = 1'b0; wr_n = 1'b0; end
            3'd3: begin iorq_n = 1'b0; rd_n = 1'b0; end
            3'd4: begin iorq_n = 1'b0; wr_n = 1'b0; end
            3'd5: begin m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0; end
            default: ;
        endcase
        cyc(hold);
        // release strobes and change the bus in the same cycle
        mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
        bus_addr = ~a;
        bus_data = ~d;
        cyc(6);
    endtask

    task automatic push_btn(int len);
        @(negedge clk);
        view_btn = 1'b1;
        cyc(len);
        view_btn = 1'b0;
        cyc(DEB + 6);
    endtask

    task automatic show(logic s);
        if (disp_sel !== s) push_btn(DEB + 6);
        check("R12 view select", {31'd0, disp_sel}, {31'd0, s});
    endtask

    function automatic logic hits(logic [2:0] code, logic [2:0] kind);
        case (code)
            3'd1: return (kind == 3'd1) || (kind == 3'd5);
            3'd2: return kind == 3'd2;
            3'd3: return kind == 3'd3;
            3'd4: return kind == 3'd4;
            3'd5: return kind == 3'd5;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string vec_req(int i);
        case (i)
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            4: return "R5";
            5, 8: return "R10";
            6: return "R9";
            default: return "R11";
        endcase
    endfunction

    initial begin
        #(20 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            exp_v[s] = 1'b0; exp_a[s] = '0; exp_d[s] = '0;
        end
        cyc(3);
        // R1: reset state
        check("R1 valid", {31'd0, disp_valid}, 32'd0);
        check("R1 sel", {31'd0, disp_sel}, 32'd0);
        check("R1 addr", {16'd0, disp_addr}, 32'd0);
        check("R1 data", {24'd0, disp_data}, 32'd0);
        rst_n = 1'b1;
        cyc(3);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            trig_sel0 = VECS[i].s0;
            trig_sel1 = VECS[i].s1;
            cyc(3);
            bus_event(VECS[i].kind, VECS[i].a, VECS[i].d, 5);
            // R6/R13: captured values are from inside the event; valid sticks
            if (hits(VECS[i].s0, VECS[i].kind)) begin
                exp_v[0] = 1'b1; exp_a[0] = VECS[i].a; exp_d[0] = VECS[i].d;
            end
            if (hits(VECS[i].s1, VECS[i].kind)) begin
                exp_v[1] = 1'b1; exp_a[1] = VECS[i].a; exp_d[1] = VECS[i].d;
            end
            for (int s = 0; s < 2; s++) begin
                show(s[0]);
                check({vec_req(i), " R13 valid"}, {31'd0, disp_valid}, {31'd0, exp_v[s]});
                check({vec_req(i), " R6 addr"}, {16'd0, disp_addr}, {16'd0, exp_a[s]});
                check({vec_req(i), " R6 data"}, {24'd0, disp_data}, {24'd0, exp_d[s]});
            end
        end

        // R7: nothing changes while the event is still active
        @(negedge clk);
        trig_sel0 = 3'd1;
        show(1'b0);
        @(negedge clk);
        bus_addr = 16'hBEEF; bus_data = 8'hC3;
        mreq_n = 1'b0; rd_n = 1'b0;
        cyc(8);
        check("R7 addr during event", {16'd0, disp_addr}, {16'd0, exp_a[0]});
        check("R7 data during event", {24'd0, disp_data}, {24'd0, exp_d[0]});
        mreq_n = 1'b1; rd_n = 1'b1;
        bus_addr = 16'h0000; bus_data = 8'h00;
        cyc(6);
        check("R2 addr after end", {16'd0, disp_addr}, 32'h0000BEEF);
        check("R2 data after end", {24'd0, disp_data}, 32'h000000C3);

        // R8: follow mode, exact three-edge latency
        @(negedge clk);
        trig_sel0 = 3'd0;
        bus_addr = 16'hABCD; bus_data = 8'h77;
        cyc(5);
        check("R8 follow addr", {16'd0, disp_addr}, 32'h0000ABCD);
        check("R8 follow data", {24'd0, disp_data}, 32'h00000077);
        check("R8 follow valid", {31'd0, disp_valid}, 32'd1);
        bus_addr = 16'h1357; bus_data = 8'h09;
        cyc(2);
        check("R8 not yet after two edges", {16'd0, disp_addr}, 32'h0000ABCD);
        cyc(1);
        check("R8 updated on third edge", {16'd0, disp_addr}, 32'h00001357);
        check("R8 data on third edge", {24'd0, disp_data}, 32'h00000009);

        // R12: debounce and edge behaviour of the view button
        @(negedge clk);
        view_btn = 1'b1;
        cyc(2);
        view_btn = 1'b0;
        cyc(DEB + 6);
        check("R12 short pulse ignored", {31'd0, disp_sel}, 32'd0);
        view_btn = 1'b1;
        cyc(DEB + 6);
        check("R12 accepted press", {31'd0, disp_sel}, 32'd1);
        cyc(20);
        check("R12 held button no repeat", {31'd0, disp_sel}, 32'd1);
        view_btn = 1'b0;
        cyc(DEB + 6);
        check("R12 release no toggle", {31'd0, disp_sel}, 32'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule